// File: doc/BRIEF.md
# Three-Phase Accumulating Sequencer

This block is a small controller-plus-datapath machine that steps through three phases, one per clock. In every phase it forms a transient difference between one selected operand and its single stored register, then loads that register with a fourth operand either plus or minus the difference. After the first phase, the sign of the difference decides whether the machine visits the middle phase or skips to the last one. After the middle phase it always moves to the last, and after the last it always returns to the first.

The arithmetic is done by two shared functional units. A source multiplexer feeds a subtractor, and an adder/subtractor combines the result with the fourth operand. A separate controller drives the multiplexer select, the add/subtract choice and the register load enable. The controller works from the current phase and from a "difference is strictly positive" flag returned by the datapath.

The phases are PH_ENTRY (code 0), PH_RISE (code 1) and PH_FOLD (code 2). The transitions are:
- PH_ENTRY to PH_RISE when the difference is positive.
- PH_ENTRY to PH_FOLD when the difference is zero or negative.
- PH_RISE to PH_FOLD unconditionally.
- PH_FOLD to PH_ENTRY unconditionally.
- Any unused code to PH_ENTRY, with the register held.

Top module: `seq_fsmd_core`

## Requirements
- R1: When `rst` is high at a rising clock edge, the next values are `phase_q` = 0 and `acc_q` = 0, whatever the operand inputs are.
- R2: In PH_ENTRY (phase code 0), the edge loads `acc_q` with `opnd_d + (opnd_a - acc_q)`.
- R3: From PH_ENTRY the next phase is PH_RISE (code 1) when `opnd_a - acc_q` is strictly greater than zero as a signed value. A zero or negative difference leads to PH_FOLD (code 2).
- R4: In PH_RISE, the edge loads `acc_q` with `opnd_d + (opnd_b - acc_q)`, and the next phase is always PH_FOLD.
- R5: In PH_FOLD, the edge loads `acc_q` with `opnd_d - (opnd_c - acc_q)`, and the next phase is always PH_ENTRY.
- R6: All data is DATA_W-bit (default 16) two's complement. Every sum and difference wraps modulo 2^DATA_W, and the sign test of R3 is applied to the wrapped difference.
- R7: `phase_q` only ever shows codes 0, 1 or 2.
- R8: Operands not selected by the current phase have no effect on `acc_q` or on the next phase. `opnd_b` and `opnd_c` are ignored in PH_ENTRY, `opnd_a` and `opnd_c` in PH_RISE, and `opnd_a` and `opnd_b` in PH_FOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a | input | DATA_W | Signed operand used in PH_ENTRY |
| opnd_b | input | DATA_W | Signed operand used in PH_RISE |
| opnd_c | input | DATA_W | Signed operand used in PH_FOLD |
| opnd_d | input | DATA_W | Signed offset combined with the difference in every phase |
| acc_q | output | DATA_W | Stored register value |
| phase_q | output | 2 | Current phase code |

## Verification
Two things meet on the same edge: the register update computed from the difference, and the branch decision taken from that same difference's sign. Two classes of difference are steered into PH_ENTRY on purpose. The first is exactly zero or plus/minus one. The second is one that overflows past the sign bit, such as 0x7FFF minus -1. These cases provoke a wrong branch or a wrong sum on the shared arithmetic. A synchronous reset that lands in the middle of a phase also collides with the load. Each outcome is compared against a reference model of the phase and register value held in the bench.

// File: rtl/seq_fsmd_pkg.sv
package seq_fsmd_pkg;

    typedef enum logic [1:0] {
        PH_ENTRY = 2'd0,
        PH_RISE  = 2'd1,
        PH_FOLD  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SRC_A = 2'd0,
        SRC_B = 2'd1,
        SRC_C = 2'd2
    } src_sel_e;

    typedef struct packed {
        src_sel_e src_sel;
        logic     add_not_sub;
        logic     load_en;
    } ctrl_word_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_fsmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       diff_pos,
    output ctrl_word_t ctrl,
    output logic [1:0] phase_q
);

    logic [1:0] state_q;
    logic [1:0] state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_ENTRY;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decision from phase and datapath flag
    always_comb begin
        state_d = PH_ENTRY;
        unique case (state_q)
            PH_ENTRY: state_d = diff_pos ? PH_RISE : PH_FOLD;
            PH_RISE:  state_d = PH_FOLD;
            PH_FOLD:  state_d = PH_ENTRY;
            default:  state_d = PH_ENTRY;
        endcase
    end

    // control word per phase
    always_comb begin
        ctrl = '{src_sel: SRC_A, add_not_sub: 1'b1, load_en: 1'b0};
        unique case (state_q)
            PH_ENTRY: ctrl = '{src_sel: SRC_A, add_not_sub: 1'b1, load_en: 1'b1};
            PH_RISE:  ctrl = '{src_sel: SRC_B, add_not_sub: 1'b1, load_en: 1'b1};
            PH_FOLD:  ctrl = '{src_sel: SRC_C, add_not_sub: 1'b0, load_en: 1'b1};
            default:  ctrl = '{src_sel: SRC_A, add_not_sub: 1'b1, load_en: 1'b0};
        endcase
    end

    assign phase_q = state_q;

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
    import seq_fsmd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_word_t        ctrl,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] opnd_c,
    input  logic [DATA_W-1:0] opnd_d,
    output logic              diff_pos,
    output logic [DATA_W-1:0] acc_q
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] src_mux;
    logic [DATA_W-1:0] diff;
    logic [DATA_W-1:0] result;

    // source multiplexer in front of the shared subtractor
    always_comb begin
        src_mux = opnd_a;
        unique case (ctrl.src_sel)
            SRC_A:   src_mux = opnd_a;
            SRC_B:   src_mux = opnd_b;
            SRC_C:   src_mux = opnd_c;
            default: src_mux = opnd_a;
        endcase
    end

    // functional unit 1: subtractor against the stored register
    assign diff = src_mux - acc_q;

    // status flag: strictly positive wrapped difference
    assign diff_pos = ~diff[MSB] & (|diff);

    // functional unit 2: add/subtract with the offset operand
    assign result = ctrl.add_not_sub ? (opnd_d + diff) : (opnd_d - diff);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (ctrl.load_en) begin
            acc_q <= result;
        end
    end

endmodule

// File: rtl/seq_fsmd_core.sv
module seq_fsmd_core
    import seq_fsmd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] opnd_c,
    input  logic [DATA_W-1:0] opnd_d,
    output logic [DATA_W-1:0] acc_q,
    output logic [1:0]        phase_q
);

    ctrl_word_t ctrl;
    logic       diff_pos;

    seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .diff_pos (diff_pos),
        .ctrl     (ctrl),
        .phase_q  (phase_q)
    );

    seq_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .opnd_c   (opnd_c),
        .opnd_d   (opnd_d),
        .diff_pos (diff_pos),
        .acc_q    (acc_q)
    );

endmodule

// File: rtl/seq_fsmd_chk.sv
module seq_fsmd_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] opnd_c,
    input logic [DATA_W-1:0] opnd_d,
    input logic [DATA_W-1:0] acc_q,
    input logic [1:0]        phase_q
);

    logic signed [DATA_W-1:0] z_entry;
    logic [DATA_W-1:0]        exp_entry;
    logic [DATA_W-1:0]        exp_rise;
    logic [DATA_W-1:0]        exp_fold;

    assign z_entry   = opnd_a - acc_q;
    assign exp_entry = opnd_d + (opnd_a - acc_q);
    assign exp_rise  = opnd_d + (opnd_b - acc_q);
    assign exp_fold  = opnd_d - (opnd_c - acc_q);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (phase_q == 2'd0 && acc_q == '0));

    assert_entry_load_R2: assert property (@(posedge clk) disable iff (rst)
        phase_q == 2'd0 |=> acc_q == $past(exp_entry));

    assert_entry_pos_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == 2'd0 && z_entry > 0) |=> phase_q == 2'd1);

    assert_entry_nonpos_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == 2'd0 && !(z_entry > 0)) |=> phase_q == 2'd2);

    assert_rise_R4: assert property (@(posedge clk) disable iff (rst)
        phase_q == 2'd1 |=> (phase_q == 2'd2 && acc_q == $past(exp_rise)));

    assert_fold_R5: assert property (@(posedge clk) disable iff (rst)
        phase_q == 2'd2 |=> (phase_q == 2'd0 && acc_q == $past(exp_fold)));

    assert_phase_legal_R7: assert property (@(posedge clk) disable iff (rst)
        phase_q != 2'd3);

endmodule

bind seq_fsmd_core seq_fsmd_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .opnd_c  (opnd_c),
    .opnd_d  (opnd_d),
    .acc_q   (acc_q),
    .phase_q (phase_q)
);

// File: tb/seq_fsmd_core_tb.sv
module seq_fsmd_core_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0, b = '0, c = '0, d = '0;
    logic [W-1:0] acc_q;
    logic [1:0]   phase_q;

    int n_chk  = 0;
    int n_fail = 0;
    logic [W-1:0] m_r = '0;
    logic [1:0]   m_s = 2'd0;
    logic         done = 1'b0;

    always #2 clk = ~clk;

    seq_fsmd_core #(.DATA_W(W)) u_dut (
        .clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .opnd_c(c), .opnd_d(d),
        .acc_q(acc_q), .phase_q(phase_q)
    );

    function automatic logic [W-1:0] diff_of(logic [1:0] s, logic [W-1:0] r,
                                             logic [W-1:0] xa, logic [W-1:0] xb,
                                             logic [W-1:0] xc);
        logic [W-1:0] src;
        src = (s == 2'd0) ? xa : (s == 2'd1) ? xb : xc;
        return src - r;
    endfunction

    task automatic check(string tag);
        n_chk++;
        if (acc_q !== m_r || phase_q !== m_s) begin
            n_fail++;
            $display("FAIL %s: acc=%h phase=%0d expected acc=%h phase=%0d",
                     tag, acc_q, phase_q, m_r, m_s);
        end
    endtask

    // drive one cycle, advance the model, compare after the edge
    task automatic cycle(logic rs, logic [W-1:0] xa, logic [W-1:0] xb,
                         logic [W-1:0] xc, logic [W-1:0] xd, string tag);
        logic [W-1:0] z;
        logic         pos;
        @(negedge clk);
        rst = rs; a = xa; b = xb; c = xc; d = xd;
        z   = diff_of(m_s, m_r, xa, xb, xc);
        pos = !z[W-1] && (z != '0);
        @(posedge clk);
        #1;
        if (rs) begin
            m_r = '0; m_s = 2'd0;
        end else begin
            unique case (m_s)
                2'd0: begin m_r = xd + z; m_s = pos ? 2'd1 : 2'd2; end
                2'd1: begin m_r = xd + z; m_s = 2'd2; end
                default: begin m_r = xd - z; m_s = 2'd0; end
            endcase
        end
        check(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: expired, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset with noisy operands
        cycle(1'b1, 16'h1234, 16'h5678, 16'h9abc, 16'hdef0, "R1 reset");
        cycle(1'b1, 16'hffff, 16'hffff, 16'hffff, 16'hffff, "R1 reset");
        // R2/R3 positive branch: z=5 -> r=8, phase 1
        cycle(1'b0, 16'd5, 16'h7777, 16'h8888, 16'd3, "R2/R3 positive");
        // R4: z=2-8=-6 -> r=4, phase 2
        cycle(1'b0, 16'h4444, 16'd2, 16'h5555, 16'd10, "R4 rise");
        // R5: z=1-4=-3 -> r=103, phase 0
        cycle(1'b0, 16'h6666, 16'h7777, 16'd1, 16'd100, "R5 fold");
        // R3 zero difference goes to fold
        cycle(1'b0, 16'd103, 16'h1111, 16'h2222, 16'd7, "R3 zero");
        cycle(1'b0, 16'h3333, 16'h4444, 16'd7, 16'd0, "R5 fold");
        // R6 wrap: set r to -1 via reset path then walk
        cycle(1'b1, 16'h0, 16'h0, 16'h0, 16'h0, "R1 reset");
        cycle(1'b0, 16'h0000, 16'h0, 16'h0, 16'hffff, "R3 zero");
        cycle(1'b0, 16'h0, 16'h0, 16'hffff, 16'hffff, "R5 fold");
        // r is now 0xffff (-1); 0x7fff - (-1) wraps to 0x8000, negative
        cycle(1'b0, 16'h7fff, 16'h0, 16'h0, 16'h7fff, "R6 wrap");
        cycle(1'b0, 16'h0, 16'h0, 16'h0, 16'h0, "R5 fold");
        // R3 difference of one, R8 ignored operands at extremes
        cycle(1'b0, m_r + 16'd1, 16'h8000, 16'h7fff, 16'd0, "R3/R8 plus one");
        cycle(1'b0, 16'h8000, m_r, 16'hffff, 16'd9, "R4/R8 rise");
        cycle(1'b0, 16'h7fff, 16'h8000, m_r - 16'd1, 16'd0, "R5/R8 fold");
        cycle(1'b0, m_r - 16'd1, 16'h1, 16'h1, 16'd0, "R3 minus one");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] ra, rb, rc, rd;
            logic         rr;
            int           k;
            ra = W'($urandom); rb = W'($urandom); rc = W'($urandom); rd = W'($urandom);
            k = $urandom_range(0, 15);
            if (k == 0) ra = m_r;
            if (k == 1) ra = m_r + 16'd1;
            if (k == 2) ra = m_r - 16'd1;
            if (k == 3) ra = 16'h7fff;
            rr = ($urandom_range(0, 63) == 0);
            cycle(rr, ra, rb, rc, rd, rr ? "R1 mid-run" :
                  (m_s == 2'd0) ? "R2/R3/R6/R7 rand" :
                  (m_s == 2'd1) ? "R4/R7/R8 rand" : "R5/R7/R8 rand");
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule